// File: doc/BRIEF.md
# SONET Transport Overhead Generator

This block sits on the transmit line side of an STS-1 or STS-3 datapath. A byte-interleaved frame stream arrives one byte per clock, together with the row and column of that byte in the frame. The block fills the section and line overhead columns, computes the B1 and B2 parities, and forces line AIS when asked. It applies frame-synchronous scrambling and hands the resulting byte stream to a parallel-to-serial converter one clock later.

Overhead values for J0, F1, K1/K2, S1 and the line REI byte come from one of two sources. The first is a byte-wide insert port, which is valid in the same cycle as the matching frame position. The second is a set of static configuration inputs. Each insert function has its own enable. A disabled function, and every overhead byte the block does not own, carries a fill word that configuration sets to all-zeros or all-ones. For test, one control corrupts the transmitted B1 and another corrupts the A2 framing bytes.

Positions use row 0..8 and a byte-interleaved column 0..90·N−1, where N is the number of STS-1s. Overhead column k of STS-1 number s sits at column k·N+s.

Top module: `toh_gen`

## Requirements
- R1: At row 0, columns 0..N−1 carry 0xF6 and columns N..2N−1 carry 0x28.
- R2: While `a2_err_i` is high, bit 0 of every A2 byte is inverted, so 0x29 is sent.
- R3: The scrambler is x^7+x^6+1 with the first state bit used as the MSB of the mask. It does not touch row-0 overhead bytes, and it restarts from all-ones after them. The byte at row 0, column 3N is therefore XORed with 0xFE. The sequence then runs on without a break to the next row 0.
- R4: Payload bytes and the row-3 overhead bytes (pointer bytes) pass from `data_i` to the output and are scrambled.
- R5: The byte at row 1, column 0 is B1. B1 is the XOR of all output bytes of the previous frame, taken after scrambling, and it is inserted before scrambling. Before the first complete frame, B1 is 0.
- R6: While `b1_err_i` is high, bit 0 of the inserted B1 is inverted.
- R7: Row 4, column s (for s in 0..N−1) holds B2 of STS-1 s. B2 is the XOR of the previous frame's pre-scramble bytes of that STS-1 in columns where col mod N = s, with rows 0..2 of the overhead columns left out.
- R8: The owned bytes sit at these positions: J0 at row 0, column 2N; F1 at row 1, column 2N; K1 at row 4, column N; K2 at row 4, column 2N; S1 at row 8, column 0; line REI at row 8, column 2N−1. When its function is enabled, each takes `oh_i` if `src_port_i`=1 and its `*_cfg_i` input otherwise.
- R9: The bits of `ins_en_i` enable the functions: bit0 J0, bit1 F1, bit2 K1 and K2, bit3 S1, bit4 REI. A cleared bit puts the fill word in place of that byte.
- R10: Every other overhead byte carries the fill word before scrambling. This covers E1, the D bytes, E2, Z0, and the B1/K/S1 and unused REI columns of STS-1s other than the owning one. The fill word is 0xFF if `fill_ones_i`=1 and 0x00 otherwise.
- R11: While `ais_i` is high, every byte outside rows 0..2 of the overhead columns is 0xFF before scrambling, B2 included. The section overhead is unchanged.
- R12: The output is registered. `data_o` shows the result for the inputs of the previous clock, and it reads 0x00 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_i | input | 4 | Frame row of the current byte, 0..8 |
| col_i | input | $clog2(90·N) | Byte-interleaved column, 0..90·N−1 |
| data_i | input | 8 | Incoming frame byte |
| oh_i | input | 8 | Overhead insert port byte for the current position |
| src_port_i | input | 1 | 1: owned bytes come from oh_i, 0: from the cfg inputs |
| ins_en_i | input | 5 | Per-function insert enables |
| fill_ones_i | input | 1 | Fill word select, 1 = 0xFF |
| ais_i | input | 1 | Line AIS request |
| b1_err_i | input | 1 | Invert bit 0 of B1 |
| a2_err_i | input | 1 | Invert bit 0 of A2 |
| j0_cfg_i | input | 8 | J0 value |
| f1_cfg_i | input | 8 | F1 value |
| k1_cfg_i | input | 8 | K1 value |
| k2_cfg_i | input | 8 | K2 value |
| s1_cfg_i | input | 8 | S1 value |
| rei_cfg_i | input | 8 | Line REI value |
| data_o | output | 8 | Scrambled line-side byte |

## Verification
Some properties can be checked on every cycle by relating the output to the inputs and the scrambler mask of the cycle before. These are the fixed and corrupted framing bytes, the 0xFE first mask after row 0, the pass-through of payload and pointer bytes, the all-ones pattern under AIS, and B1 holding still within a frame. Other behaviour only shows up across whole frames in the bench's reference model: the B1 and B2 values carried over from one frame to the next, the source and enable selection for each owned byte, the fill word on unowned bytes, and B2 taking on the AIS all-ones bytes.

// File: rtl/toh_pkg.sv
package toh_pkg;
  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;
  localparam int EN_J0  = 0;
  localparam int EN_F1  = 1;
  localparam int EN_K   = 2;
  localparam int EN_S1  = 3;
  localparam int EN_REI = 4;
  localparam int EN_W   = 5;

  typedef enum logic [3:0] {
    BK_PAY, BK_A1, BK_A2, BK_J0, BK_B1, BK_F1, BK_PTR,
    BK_B2, BK_K1, BK_K2, BK_S1, BK_REI, BK_FILL
  } byte_kind_e;
endpackage

// File: rtl/toh_pos_decode.sv
module toh_pos_decode
  import toh_pkg::*;
#(
  parameter int N_STS = 3,
  parameter int COL_W = 9,
  parameter int STS_W = 2
) (
  input  logic [3:0]       row_i,
  input  logic [COL_W-1:0] col_i,
  output byte_kind_e       kind_o,
  output logic [STS_W-1:0] sts_o,
  output logic             soh_o,
  output logic             scr_skip_o,
  output logic             frame_end_o
);
  localparam int COLS    = 90 * N_STS;
  localparam int OH_COLS = 3 * N_STS;

  always_comb begin
    int c, r, ohc, st;
    logic oh;
    c   = int'(col_i);
    r   = int'(row_i);
    ohc = c / N_STS;
    st  = c % N_STS;
    oh  = c < OH_COLS;
    kind_o = BK_PAY;
    if (oh) begin
      kind_o = BK_FILL;
      case (r)
        0: kind_o = (ohc == 0) ? BK_A1 : (ohc == 1) ? BK_A2 : (st == 0) ? BK_J0 : BK_FILL;
        1: begin
          if (ohc == 0 && st == 0) kind_o = BK_B1;
          else if (ohc == 2 && st == 0) kind_o = BK_F1;
        end
        3: kind_o = BK_PTR;
        4: begin
          if (ohc == 0) kind_o = BK_B2;
          else if (st == 0) kind_o = (ohc == 1) ? BK_K1 : BK_K2;
        end
        8: begin
          if (ohc == 0 && st == 0) kind_o = BK_S1;
          else if (ohc == 1 && st == N_STS - 1) kind_o = BK_REI;
        end
        default: kind_o = BK_FILL;
      endcase
    end
    sts_o       = STS_W'(st);
    soh_o       = oh && (r < 3);
    scr_skip_o  = oh && (r == 0);
    frame_end_o = (r == 8) && (c == COLS - 1);
  end
endmodule

// File: rtl/toh_scrambler.sv
module toh_scrambler (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       skip_i,
  output logic [7:0] mask_o
);
  logic [6:0] st_q, st_adv;
  logic [7:0] mask_raw;

  // x^7+x^6+1, eight bit steps per byte, MSB first
  always_comb begin
    logic [6:0] t;
    t = st_q;
    for (int i = 7; i >= 0; i--) begin
      mask_raw[i] = t[6];
      t = {t[5:0], t[6] ^ t[5]};
    end
    st_adv = t;
  end

  assign mask_o = skip_i ? 8'h00 : mask_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= 7'h7F;
    else if (skip_i) st_q <= 7'h7F;
    else             st_q <= st_adv;
  end
endmodule

// File: rtl/toh_bip.sv
module toh_bip #(
  parameter int N_STS = 3,
  parameter int STS_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_end_i,
  input  logic               soh_i,
  input  logic [STS_W-1:0]   sts_i,
  input  logic [7:0]         pre_i,
  input  logic [7:0]         out_i,
  output logic [7:0]         b1_o,
  output logic [8*N_STS-1:0] b2_o
);
  logic [7:0] b1_acc, b1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_acc <= '0;
      b1_q   <= '0;
    end else if (frame_end_i) begin
      b1_q   <= b1_acc ^ out_i;
      b1_acc <= '0;
    end else begin
      b1_acc <= b1_acc ^ out_i;
    end
  end
  assign b1_o = b1_q;

  for (genvar g = 0; g < N_STS; g++) begin : g_b2
    logic [7:0] acc, q, term;
    logic hit;
    assign hit  = !soh_i && (sts_i == STS_W'(g));
    assign term = hit ? pre_i : 8'h00;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc <= '0;
        q   <= '0;
      end else if (frame_end_i) begin
        q   <= acc ^ term;
        acc <= '0;
      end else begin
        acc <= acc ^ term;
      end
    end
    assign b2_o[8*g +: 8] = q;
  end
endmodule

// File: rtl/toh_gen.sv
module toh_gen
  import toh_pkg::*;
#(
  parameter int N_STS = 3,
  localparam int COLS  = 90 * N_STS,
  localparam int COL_W = $clog2(COLS),
  localparam int STS_W = (N_STS > 1) ? $clog2(N_STS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [7:0]       data_i,
  input  logic [7:0]       oh_i,
  input  logic             src_port_i,
  input  logic [EN_W-1:0]  ins_en_i,
  input  logic             fill_ones_i,
  input  logic             ais_i,
  input  logic             b1_err_i,
  input  logic             a2_err_i,
  input  logic [7:0]       j0_cfg_i,
  input  logic [7:0]       f1_cfg_i,
  input  logic [7:0]       k1_cfg_i,
  input  logic [7:0]       k2_cfg_i,
  input  logic [7:0]       s1_cfg_i,
  input  logic [7:0]       rei_cfg_i,
  output logic [7:0]       data_o
);
  byte_kind_e         kind;
  logic [STS_W-1:0]   sts;
  logic               soh, scr_skip, frame_end;
  logic [7:0]         scr_mask, b1_val, fill, pre_raw, pre_byte, out_byte;
  logic [8*N_STS-1:0] b2_vec;

  toh_pos_decode #(.N_STS(N_STS), .COL_W(COL_W), .STS_W(STS_W)) u_dec (
    .row_i(row_i), .col_i(col_i), .kind_o(kind), .sts_o(sts),
    .soh_o(soh), .scr_skip_o(scr_skip), .frame_end_o(frame_end)
  );

  toh_scrambler u_scr (
    .clk_i(clk_i), .rst_ni(rst_ni), .skip_i(scr_skip), .mask_o(scr_mask)
  );

  toh_bip #(.N_STS(N_STS), .STS_W(STS_W)) u_bip (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(frame_end), .soh_i(soh),
    .sts_i(sts), .pre_i(pre_byte), .out_i(out_byte), .b1_o(b1_val), .b2_o(b2_vec)
  );

  assign fill = {8{fill_ones_i}};

  function automatic logic [7:0] pick(input logic en, input logic [7:0] cfg,
                                      input logic [7:0] port, input logic sel,
                                      input logic [7:0] fw);
    if (!en) return fw;
    return sel ? port : cfg;
  endfunction

  always_comb begin
    case (kind)
      BK_PAY, BK_PTR: pre_raw = data_i;
      BK_A1:  pre_raw = A1_BYTE;
      BK_A2:  pre_raw = A2_BYTE ^ {7'd0, a2_err_i};
      BK_J0:  pre_raw = pick(ins_en_i[EN_J0], j0_cfg_i, oh_i, src_port_i, fill);
      BK_B1:  pre_raw = b1_val ^ {7'd0, b1_err_i};
      BK_F1:  pre_raw = pick(ins_en_i[EN_F1], f1_cfg_i, oh_i, src_port_i, fill);
      BK_B2:  pre_raw = b2_vec[8*sts +: 8];
      BK_K1:  pre_raw = pick(ins_en_i[EN_K], k1_cfg_i, oh_i, src_port_i, fill);
      BK_K2:  pre_raw = pick(ins_en_i[EN_K], k2_cfg_i, oh_i, src_port_i, fill);
      BK_S1:  pre_raw = pick(ins_en_i[EN_S1], s1_cfg_i, oh_i, src_port_i, fill);
      BK_REI: pre_raw = pick(ins_en_i[EN_REI], rei_cfg_i, oh_i, src_port_i, fill);
      default: pre_raw = fill;
    endcase
  end

  assign pre_byte = (ais_i && !soh) ? 8'hFF : pre_raw;
  assign out_byte = pre_byte ^ scr_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= out_byte;
  end
endmodule

// File: rtl/toh_gen_chk.sv
module toh_gen_chk #(
  parameter int N_STS = 3,
  parameter int COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       row_i,
  input logic [COL_W-1:0] col_i,
  input logic [7:0]       data_i,
  input logic             ais_i,
  input logic             a2_err_i,
  input logic [7:0]       mask_i,
  input logic [7:0]       b1_i,
  input logic             frame_end_i,
  input logic [7:0]       data_o
);
  localparam logic [COL_W-1:0] C_N   = COL_W'(N_STS);
  localparam logic [COL_W-1:0] C_2N  = COL_W'(2 * N_STS);
  localparam logic [COL_W-1:0] C_OHC = COL_W'(3 * N_STS);

  AST_A1_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_i == 4'd0 && col_i < C_N) |=> data_o == 8'hF6); // R1

  AST_A2_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_i == 4'd0 && col_i >= C_N && col_i < C_2N)
      |=> data_o == (8'h28 ^ {7'd0, $past(a2_err_i)})); // R2

  AST_SCR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_i == 4'd0 && col_i == C_OHC && !ais_i)
      |=> data_o == ($past(data_i) ^ 8'hFE)); // R3

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((col_i >= C_OHC || row_i == 4'd3) && !ais_i)
      |=> (data_o ^ $past(mask_i)) == $past(data_i)); // R4

  AST_B1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(b1_i)); // R5

  AST_AIS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ais_i && (row_i >= 4'd3 || col_i >= C_OHC))
      |=> (data_o ^ $past(mask_i)) == 8'hFF); // R11
endmodule

bind toh_gen toh_gen_chk #(.N_STS(N_STS), .COL_W(COL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .row_i(row_i), .col_i(col_i),
  .data_i(data_i), .ais_i(ais_i), .a2_err_i(a2_err_i), .mask_i(scr_mask),
  .b1_i(b1_val), .frame_end_i(frame_end), .data_o(data_o)
);

// File: tb/toh_gen_tb_top.sv
`timescale 1ns/1ps
module toh_gen_tb_top;
  localparam int N     = 3;
  localparam int COLS  = 90 * N;
  localparam int COL_W = $clog2(COLS);
  localparam int OHC   = 3 * N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] row = '0;
  logic [COL_W-1:0] col = '0;
  logic [7:0] din = '0, oh = '0, data_o;
  logic src = 1'b0, fill1 = 1'b0, ais = 1'b0, b1e = 1'b0, a2e = 1'b0;
  logic [4:0] en = '1;
  logic [7:0] j0c = 8'h01, f1c = 8'h02, k1c = 8'h03, k2c = 8'h04, s1c = 8'h05, reic = 8'h06;

  always #10 clk = ~clk;

  toh_gen #(.N_STS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .row_i(row), .col_i(col), .data_i(din), .oh_i(oh),
    .src_port_i(src), .ins_en_i(en), .fill_ones_i(fill1), .ais_i(ais),
    .b1_err_i(b1e), .a2_err_i(a2e), .j0_cfg_i(j0c), .f1_cfg_i(f1c), .k1_cfg_i(k1c),
    .k2_cfg_i(k2c), .s1_cfg_i(s1c), .rei_cfg_i(reic), .data_o(data_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit pn[127];
  int pn_idx = 0;
  logic [7:0] b1_acc = 0, b1_prev = 0;
  logic [7:0] b2_acc[N], b2_prev[N];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s row %0d col %0d act %02h exp %02h", req, row, col, act, exp);
    end
  endtask

  function automatic logic [7:0] owned(input bit e, input logic [7:0] cfg, output string rq);
    logic [7:0] fw;
    fw = fill1 ? 8'hFF : 8'h00;
    rq = e ? "R8" : "R9";
    return e ? (src ? oh : cfg) : fw;
  endfunction

  // behavioural reference: returns expected output byte for current inputs, advances state
  task automatic model(output logic [7:0] exp, output string rq);
    int r, c, k, s;
    bit is_oh, is_soh;
    logic [7:0] pre, msk, fw;
    r = int'(row); c = int'(col);
    is_oh = c < OHC; is_soh = is_oh && r < 3;
    k = c / N; s = c % N;
    fw = fill1 ? 8'hFF : 8'h00;
    pre = fw; rq = "R10";
    if (!is_oh) begin pre = din; rq = "R4"; end
    else if (r == 3) begin pre = din; rq = "R4"; end
    else if (r == 0 && k == 0) begin pre = 8'hF6; rq = "R1"; end
    else if (r == 0 && k == 1) begin pre = a2e ? 8'h29 : 8'h28; rq = a2e ? "R2" : "R1"; end
    else if (r == 0 && s == 0) pre = owned(en[0], j0c, rq);
    else if (r == 1 && k == 0 && s == 0) begin pre = b1_prev ^ {7'd0, b1e}; rq = b1e ? "R6" : "R5"; end
    else if (r == 1 && k == 2 && s == 0) pre = owned(en[1], f1c, rq);
    else if (r == 4 && k == 0) begin pre = b2_prev[s]; rq = "R7"; end
    else if (r == 4 && k == 1 && s == 0) pre = owned(en[2], k1c, rq);
    else if (r == 4 && k == 2 && s == 0) pre = owned(en[2], k2c, rq);
    else if (r == 8 && k == 0 && s == 0) pre = owned(en[3], s1c, rq);
    else if (r == 8 && k == 1 && s == N - 1) pre = owned(en[4], reic, rq);
    if (ais && !is_soh) begin pre = 8'hFF; rq = "R11"; end
    if (r == 0 && is_oh) begin
      msk = 8'h00; pn_idx = 0;
    end else begin
      if (r == 0 && c == OHC && rq == "R4") rq = "R3";
      for (int b = 0; b < 8; b++) msk[7-b] = pn[(pn_idx + b) % 127];
      pn_idx = (pn_idx + 8) % 127;
    end
    exp = pre ^ msk;
    b1_acc ^= exp;
    if (!is_soh) b2_acc[s] ^= pre;
    if (r == 8 && c == COLS - 1) begin
      b1_prev = b1_acc; b1_acc = 0;
      for (int i = 0; i < N; i++) begin b2_prev[i] = b2_acc[i]; b2_acc[i] = 0; end
    end
  endtask

  task automatic run_frame(input bit p_src, input logic [4:0] p_en, input bit p_fill,
                           input bit p_ais, input bit p_b1e, input bit p_a2e);
    logic [7:0] exp;
    string rq;
    src = p_src; en = p_en; fill1 = p_fill; ais = p_ais; b1e = p_b1e; a2e = p_a2e;
    j0c = 8'($urandom); f1c = 8'($urandom); k1c = 8'($urandom);
    k2c = 8'($urandom); s1c = 8'($urandom); reic = 8'($urandom);
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < COLS; c++) begin
        row = 4'(r); col = COL_W'(c);
        din = 8'($urandom); oh = 8'($urandom);
        @(posedge clk);
        model(exp, rq);
        @(negedge clk);
        check(rq, data_o, exp);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 127; k++) pn[k] = (k < 7) ? 1'b1 : (pn[k-7] ^ pn[k-6]);
    for (int i = 0; i < N; i++) begin b2_acc[i] = 0; b2_prev[i] = 0; end
    repeat (3) @(negedge clk);
    check("R12", data_o, 8'h00);
    rst_n = 1'b1;
    run_frame(1'b0, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame(1'b1, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame(1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame(1'b1, 5'b10101, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame(1'b0, 5'b01010, 1'b1, 1'b1, 1'b0, 1'b0);
    run_frame(1'b0, 5'b11111, 1'b0, 1'b0, 1'b1, 1'b1);
    run_frame(1'b1, 5'b11111, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame(1'b0, 5'b11111, 1'b1, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired R12");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule